// File: doc/BRIEF.md
# Packed-Pixel Read-Modify-Write Writer

This block turns single-pixel write commands into memory traffic on a frame buffer held in shared 16-bit-word memory. A command names a word address, a bit offset within that word, a colour and a pixel depth of 1, 2, 4 or 8 bits. Pixels narrower than a word share it with their neighbours, so the block first reads the destination word through one of two read ports, replaces only the addressed field with the low bits of the colour, and writes the whole word back. Fields are packed from the most significant end, so the first pixel in a word sits in its top bits.

While a pixel is in flight the block raises a busy output so that the upstream address generator holds off, and it accepts no further command until the write-back has been taken by the memory multiplexer. The multiplexer can stall any request with its own busy input; the block then holds the request unchanged. Two saturating counters record how often a pixel landed on a non-zero destination, one for any colour and one for non-zero colours only, and each can be cleared by the host after it reads the value.

Top module: `pix_rmw_writer`

## Requirements
- R1: After reset both read requests and the write enable are low, busy is low and both collision counters read zero.
- R2: A command is taken only in a cycle where busy is low and the command valid input is high; busy is high from the next cycle until the write-back has been accepted, and command valid while busy is high has no effect.
- R3: A taken command issues a read request on port A when its port select bit is 0 and on port B when it is 1, with the command's word address on the address output; while the memory busy input is high the request and address stay unchanged.
- R4: Read data is captured only in a cycle where the ready input of the port that was requested is high; a ready pulse on the other port is ignored.
- R5: After the read data arrives, the write enable is raised with the same address and the merged word; while the memory busy input is high the write enable, address and data stay unchanged, and it drops once the write is accepted.
- R6: Depth code 0, 1, 2, 3 selects 1, 2, 4, 8 bits per pixel. The offset input, with its low log2(depth) bits cleared, counts bits from the word's most significant bit, so the field occupies bits [15-off : 16-off-depth]; the even byte of a word is bits 15:8. Only the low depth bits of the colour are stored, and every other bit of the word is written back unchanged.
- R7: The read-collision counter increases by one for each written pixel whose previous field value was non-zero, whatever the new colour, and does not change when it was zero.
- R8: The write-collision counter increases by one only when both the previous field value and the stored colour bits are non-zero.
- R9: Both counters stop at 255 and stay there under further collisions.
- R10: A high clear input sets its counter to zero in the next cycle and takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Pixel command present |
| cmd_addr | input | 20 | Destination word address |
| cmd_off | input | 4 | Bit offset of the pixel from the word's MSB |
| cmd_colour | input | 8 | Pixel colour; low depth bits are used |
| cmd_depth | input | 2 | Depth code: 0=1, 1=2, 2=4, 3=8 bits |
| cmd_port_b | input | 1 | 0 reads through port A, 1 through port B |
| busy_o | output | 1 | Upstream must hold commands |
| rd_req_a | output | 1 | Read request, port A |
| rd_req_b | output | 1 | Read request, port B |
| rd_rdy_a | input | 1 | Read data valid, port A |
| rd_rdy_b | input | 1 | Read data valid, port B |
| rd_data | input | 16 | Read data word |
| mem_busy | input | 1 | Memory multiplexer cannot take a request |
| wr_ena | output | 1 | Write request |
| ram_addr | output | 20 | Word address for read and write |
| ram_wr_data | output | 16 | Merged word to write |
| coll_rd_clr | input | 1 | Clear read-collision counter |
| coll_wr_clr | input | 1 | Clear write-collision counter |
| coll_rd_cnt | output | 8 | Read-collision count |
| coll_wr_cnt | output | 8 | Write-collision count |

## Verification
The hardest situation to reach is a collision that coincides with a counter clear, together with the stalls around it: the increment happens in the single cycle the read data returns, so the bench holds the clear high across a whole colliding command and expects the counter to stay at zero. Stalls are produced by a memory model that raises its busy input in a repeating pattern, catching both the read request and the write-back mid-flight, and a mode that pulses the ready of the unrequested port with a decoy word before the real reply. Saturation is reached by writing the same pixel 260 times with a non-zero colour.

// File: rtl/pixw_pkg.sv
package pixw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_WR   = 2'd3
  } pixw_state_e;

  localparam int COL_W = 8;
  localparam int DEPTH_CODE_W = 2;
endpackage

// File: rtl/pixw_field.sv
module pixw_field
  import pixw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]       word_i,
  input  logic [COL_W-1:0]        colour_i,
  input  logic [DEPTH_CODE_W-1:0] depth_i,
  input  logic [OFF_W-1:0]        off_i,
  output logic [DATA_W-1:0]       word_o,
  output logic                    old_nz_o,
  output logic                    col_nz_o
);
  logic [3:0]        width;
  logic [COL_W-1:0]  low_mask;
  logic [OFF_W-1:0]  off_al;
  logic [OFF_W:0]    pos;
  logic [DATA_W-1:0] field_mask;
  logic [COL_W-1:0]  col_bits;
  logic [COL_W-1:0]  old_bits;

  always_comb begin
    width      = 4'd1 << depth_i;
    low_mask   = COL_W'((9'd1 << width) - 9'd1);
    off_al     = off_i & ~(OFF_W'(width - 4'd1));
    pos        = (OFF_W+1)'(DATA_W) - {1'b0, off_al} - (OFF_W+1)'(width);
    field_mask = DATA_W'(low_mask) << pos;
    col_bits   = colour_i & low_mask;
    old_bits   = COL_W'(word_i >> pos) & low_mask;
    word_o     = (word_i & ~field_mask) | (DATA_W'(col_bits) << pos);
    old_nz_o   = |old_bits;
    col_nz_o   = |col_bits;
  end
endmodule

// File: rtl/pixw_satcnt.sv
module pixw_satcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i || (inc_i && (cnt_q != CNT_MAX));
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r9_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == CNT_MAX && !clr_i) |=> cnt_o == CNT_MAX);
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_o == '0);
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/pix_rmw_writer.sv
module pix_rmw_writer
  import pixw_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [ADDR_W-1:0]          cmd_addr,
  input  logic [$clog2(DATA_W)-1:0]  cmd_off,
  input  logic [7:0]                 cmd_colour,
  input  logic [1:0]                 cmd_depth,
  input  logic                       cmd_port_b,
  output logic                       busy_o,
  output logic                       rd_req_a,
  output logic                       rd_req_b,
  input  logic                       rd_rdy_a,
  input  logic                       rd_rdy_b,
  input  logic [DATA_W-1:0]          rd_data,
  input  logic                       mem_busy,
  output logic                       wr_ena,
  output logic [ADDR_W-1:0]          ram_addr,
  output logic [DATA_W-1:0]          ram_wr_data,
  input  logic                       coll_rd_clr,
  input  logic                       coll_wr_clr,
  output logic [CNT_W-1:0]           coll_rd_cnt,
  output logic [CNT_W-1:0]           coll_wr_cnt
);
  localparam int OFF_W  = $clog2(DATA_W);
  localparam int N_CNT  = 2;
  localparam int IX_RD  = 0;
  localparam int IX_WR  = 1;

  pixw_state_e st_q, st_d;
  logic [ADDR_W-1:0]       addr_q;
  logic [OFF_W-1:0]        off_q;
  logic [COL_W-1:0]        col_q;
  logic [DEPTH_CODE_W-1:0] depth_q;
  logic                    selb_q;
  logic [DATA_W-1:0]       wdata_q;

  logic load_en, cap_en, rdy_sel;
  logic [DATA_W-1:0] merged;
  logic old_nz, col_nz;

  assign rdy_sel = selb_q ? rd_rdy_b : rd_rdy_a;

  always_comb begin
    st_d    = st_q;
    load_en = 1'b0;
    cap_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (cmd_valid) begin
        load_en = 1'b1;
        st_d    = ST_REQ;
      end
      ST_REQ:  if (!mem_busy) st_d = ST_WAIT;
      ST_WAIT: if (rdy_sel) begin
        cap_en = 1'b1;
        st_d   = ST_WR;
      end
      ST_WR:   if (!mem_busy) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      off_q   <= '0;
      col_q   <= '0;
      depth_q <= '0;
      selb_q  <= 1'b0;
      wdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (load_en) begin
        addr_q  <= cmd_addr;
        off_q   <= cmd_off;
        col_q   <= cmd_colour;
        depth_q <= cmd_depth;
        selb_q  <= cmd_port_b;
      end
      if (cap_en) wdata_q <= merged;
    end
  end

  pixw_field #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_field (
    .word_i   (rd_data),
    .colour_i (col_q),
    .depth_i  (depth_q),
    .off_i    (off_q),
    .word_o   (merged),
    .old_nz_o (old_nz),
    .col_nz_o (col_nz)
  );

  logic [N_CNT-1:0] cnt_inc, cnt_clr;
  logic [CNT_W-1:0] cnt_val [N_CNT];

  assign cnt_inc[IX_RD] = cap_en && old_nz;
  assign cnt_inc[IX_WR] = cap_en && old_nz && col_nz;
  assign cnt_clr[IX_RD] = coll_rd_clr;
  assign cnt_clr[IX_WR] = coll_wr_clr;

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    pixw_satcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (cnt_inc[g]),
      .clr_i (cnt_clr[g]),
      .cnt_o (cnt_val[g])
    );
  end

  assign coll_rd_cnt = cnt_val[IX_RD];
  assign coll_wr_cnt = cnt_val[IX_WR];

  assign busy_o      = (st_q != ST_IDLE);
  assign rd_req_a    = (st_q == ST_REQ) && !selb_q;
  assign rd_req_b    = (st_q == ST_REQ) &&  selb_q;
  assign wr_ena      = (st_q == ST_WR);
  assign ram_addr    = addr_q;
  assign ram_wr_data = wdata_q;

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(rd_req_a || rd_req_b || wr_ena));
  a_r2_take_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && cmd_valid) |=> (busy_o && (rd_req_a || rd_req_b)));
  a_r3_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_a, rd_req_b, wr_ena}));
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_req_a || rd_req_b) && mem_busy) |=>
      ($stable({rd_req_a, rd_req_b}) && $stable(ram_addr)));
  a_r5_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ena && mem_busy) |=> (wr_ena && $stable(ram_addr) && $stable(ram_wr_data)));
  a_r5_write_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ena && !mem_busy) |=> !wr_ena);
endmodule

// File: tb/pix_rmw_writer_tb_top.sv
module pix_rmw_writer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cmd_valid = 1'b0;
  logic [19:0] cmd_addr = '0;
  logic [3:0]  cmd_off = '0;
  logic [7:0]  cmd_colour = '0;
  logic [1:0]  cmd_depth = '0;
  logic        cmd_port_b = 1'b0;
  logic        busy_o, rd_req_a, rd_req_b, wr_ena;
  logic        rd_rdy_a, rd_rdy_b, mem_busy;
  logic [15:0] rd_data, ram_wr_data;
  logic [19:0] ram_addr;
  logic        coll_rd_clr = 1'b0, coll_wr_clr = 1'b0;
  logic [7:0]  coll_rd_cnt, coll_wr_cnt;

  pix_rmw_writer dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_off(cmd_off), .cmd_colour(cmd_colour), .cmd_depth(cmd_depth),
    .cmd_port_b(cmd_port_b), .busy_o(busy_o), .rd_req_a(rd_req_a),
    .rd_req_b(rd_req_b), .rd_rdy_a(rd_rdy_a), .rd_rdy_b(rd_rdy_b),
    .rd_data(rd_data), .mem_busy(mem_busy), .wr_ena(wr_ena),
    .ram_addr(ram_addr), .ram_wr_data(ram_wr_data), .coll_rd_clr(coll_rd_clr),
    .coll_wr_clr(coll_wr_clr), .coll_rd_cnt(coll_rd_cnt), .coll_wr_cnt(coll_wr_cnt)
  );

  typedef struct {
    logic [19:0] a;
    logic [15:0] d;
    logic        selb;
    logic [7:0]  crd;
    logic [7:0]  cwr;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_err = 0, n_wr = 0, n_exp_wr = 0;
  int e_rd = 0, e_wr = 0;
  bit busy_mode = 0, decoy_mode = 0;
  int lat = 1;
  logic [15:0] ref_mem [0:63];
  logic [15:0] mem [0:63];

  function automatic logic [15:0] init_word(input int i);
    return (i < 8) ? 16'h0000 : 16'((i * 16'h1357) ^ 16'h8421);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // responder and monitor, all at the falling edge
  int cyc = 0, lat_cnt = 0;
  logic pend_b = 0;
  logic [5:0] pend_a = '0;
  always @(negedge clk) begin
    bit nb;
    exp_t it;
    cyc++;
    nb = busy_mode && (cyc % 4 != 3);
    mem_busy <= nb;
    rd_rdy_a <= 1'b0;
    rd_rdy_b <= 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
      lat_cnt <= 0;
      mem_busy <= 1'b0;
      rd_data <= '0;
    end else begin
      if (lat_cnt > 0) begin
        if (lat_cnt == 1) begin
          if (pend_b) rd_rdy_b <= 1'b1; else rd_rdy_a <= 1'b1;
          rd_data <= mem[pend_a];
        end else if (decoy_mode && lat_cnt == 2) begin
          if (pend_b) rd_rdy_a <= 1'b1; else rd_rdy_b <= 1'b1;
          rd_data <= 16'hA5A5;
        end
        lat_cnt <= lat_cnt - 1;
      end else if ((rd_req_a || rd_req_b) && !nb) begin
        lat_cnt <= lat;
        pend_b <= rd_req_b;
        pend_a <= ram_addr[5:0];
        if (exp_q.size() == 0) chk(0, "R3 request with no command", {12'd0, ram_addr}, 0);
        else chk(rd_req_b == exp_q[0].selb && ram_addr == exp_q[0].a,
                 "R3 read port/address", {11'd0, rd_req_b, ram_addr}, {11'd0, exp_q[0].selb, exp_q[0].a});
      end
      if (wr_ena && !nb) begin
        n_wr++;
        mem[ram_addr[5:0]] <= ram_wr_data;
        if (exp_q.size() == 0) chk(0, "R2 unexpected write", {12'd0, ram_addr}, 0);
        else begin
          it = exp_q.pop_front();
          chk(ram_addr == it.a, "R5 write address", {12'd0, ram_addr}, {12'd0, it.a});
          chk(ram_wr_data == it.d, "R6 merged word", {16'd0, ram_wr_data}, {16'd0, it.d});
          chk(coll_rd_cnt == it.crd, "R7 read collisions", {24'd0, coll_rd_cnt}, {24'd0, it.crd});
          chk(coll_wr_cnt == it.cwr, "R8 write collisions", {24'd0, coll_wr_cnt}, {24'd0, it.cwr});
        end
      end
    end
  end

  // driver: computes the expected word and counts, then issues the command
  task automatic send(input logic [19:0] a, input int off, input logic [7:0] col,
                      input int depth, input bit selb);
    int w, offa, pos;
    logic [15:0] lm, oldv, cv, nw;
    exp_t it;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    w = 1 << depth;
    offa = off & ~(w - 1);
    pos = 16 - offa - w;
    lm = 16'((1 << w) - 1);
    oldv = (ref_mem[a[5:0]] >> pos) & lm;
    cv = {8'd0, col} & lm;
    nw = (ref_mem[a[5:0]] & ~(lm << pos)) | (cv << pos);
    ref_mem[a[5:0]] = nw;
    if (coll_rd_clr) e_rd = 0; else if (oldv != 0 && e_rd < 255) e_rd++;
    if (coll_wr_clr) e_wr = 0; else if (oldv != 0 && cv != 0 && e_wr < 255) e_wr++;
    it.a = a; it.d = nw; it.selb = selb; it.crd = 8'(e_rd); it.cwr = 8'(e_wr);
    exp_q.push_back(it);
    n_exp_wr++;
    cmd_valid = 1'b1; cmd_addr = a; cmd_off = 4'(off); cmd_colour = col;
    cmd_depth = 2'(depth); cmd_port_b = selb;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after accept", {31'd0, busy_o}, 1);
  endtask

  task automatic drain();
    @(negedge clk);
    while (busy_o || exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    int guard = 0;
    forever begin
      @(posedge clk);
      guard++;
      if (guard > 150000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = init_word(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o && !rd_req_a && !rd_req_b && !wr_ena, "R1 idle outputs",
        {28'd0, busy_o, rd_req_a, rd_req_b, wr_ena}, 0);
    chk(coll_rd_cnt == 0 && coll_wr_cnt == 0, "R1 counters zero",
        {16'd0, coll_rd_cnt, coll_wr_cnt}, 0);

    // R6 placement across depths, R3 port choice, R7 no collision on zero words
    send(20'h00001, 0, 8'h3C, 3, 0);   // 8bpp even byte
    send(20'h00001, 8, 8'hC3, 3, 1);   // 8bpp odd byte
    send(20'h00002, 4, 8'hF9, 2, 0);   // 4bpp second nibble
    send(20'h00003, 2, 8'h02, 1, 1);   // 2bpp pixel 1 -> bits 13:12
    send(20'h00003, 9, 8'h03, 1, 0);   // offset low bit ignored -> bits 7:6
    send(20'h00004, 5, 8'hFE, 0, 1);   // 1bpp, only LSB stored (zero)
    send(20'h00004, 15, 8'h01, 0, 0);  // 1bpp bit 0
    drain();

    // R7/R8 collisions over non-zero destination words
    send(20'h00010, 0, 8'h00, 3, 0);   // zero colour over non-zero: rd only
    send(20'h00011, 12, 8'h05, 2, 1);  // non-zero over non-zero: both
    send(20'h00001, 8, 8'h11, 3, 0);   // over pixel written earlier
    drain();

    // R3/R5 under memory stalls
    busy_mode = 1;
    lat = 2;
    for (int i = 0; i < 8; i++) send(20'(16 + i), i * 2, 8'(i + 1), 1, i[0]);
    drain();
    busy_mode = 0;

    // R4 decoy ready on the unrequested port
    decoy_mode = 1;
    lat = 3;
    send(20'h00020, 0, 8'h77, 3, 0);
    send(20'h00021, 4, 8'h0A, 2, 1);
    drain();
    decoy_mode = 0;
    lat = 1;

    // R2 command valid held while busy is ignored
    send(20'h00022, 0, 8'h01, 3, 0);
    cmd_valid = 1'b1; cmd_addr = 20'h00030; cmd_colour = 8'hEE;
    @(negedge clk);
    cmd_valid = 1'b0;
    drain();
    repeat (10) @(negedge clk);
    chk(n_wr == n_exp_wr && exp_q.size() == 0, "R2 no extra write", 32'(n_wr), 32'(n_exp_wr));

    // R9 saturation
    for (int i = 0; i < 260; i++) send(20'h00030, 0, 8'h5A, 3, i[0]);
    drain();
    chk(coll_rd_cnt == 8'd255, "R9 read counter saturated", {24'd0, coll_rd_cnt}, 255);
    chk(coll_wr_cnt == 8'd255, "R9 write counter saturated", {24'd0, coll_wr_cnt}, 255);

    // R10 clear of one counter leaves the other
    @(negedge clk);
    coll_rd_clr = 1'b1;
    @(negedge clk);
    coll_rd_clr = 1'b0;
    e_rd = 0;
    chk(coll_rd_cnt == 0, "R10 read counter cleared", {24'd0, coll_rd_cnt}, 0);
    chk(coll_wr_cnt == 8'd255, "R10 write counter kept", {24'd0, coll_wr_cnt}, 255);

    // R10 clear held across a colliding command wins over the increment
    coll_wr_clr = 1'b1;
    coll_rd_clr = 1'b1;
    send(20'h00030, 0, 8'h5A, 3, 0);
    drain();
    coll_wr_clr = 1'b0;
    coll_rd_clr = 1'b0;
    @(negedge clk);
    chk(coll_rd_cnt == 0 && coll_wr_cnt == 0, "R10 clear beats increment",
        {16'd0, coll_rd_cnt, coll_wr_cnt}, 0);

    // one more collision counts from zero again (R7, R8)
    send(20'h00030, 0, 8'h21, 3, 1);
    drain();
    finish_run();
  end
endmodule